// File: doc/BRIEF.md
# Masked Pipelined Majority Counter

This block counts how many of its 48 hit inputs are asserted and enabled. It gives the binary sum as a new result on every clock. Each hit line has its own enable bit in a 48-bit mask. Software loads the mask over a 24-bit data bus, one half at a time, and can read either half back. The block is meant to run from a 40 MHz clock, so a new result appears every 25 ns. It feeds trigger logic that needs to know how many channels fired in the same sampling window.

Each clock, the hit lines are sampled and gated with the mask in one register stage. A second stage adds bits into leaf counts over groups of eight. A registered binary adder tree then combines the leaf counts. Delay registers are added after the tree so that the total latency is exactly seven clocks (175 ns at 40 MHz), whatever the depth of the tree.

A small controller has two states, FILL and RUN. It raises the valid flag once the pipeline holds a result from a real sample:
- Reset puts the controller in FILL.
- FILL counts clock edges and moves to RUN on the seventh edge after reset is released.
- RUN holds until the next reset.

Top module: `majority_counter`

## Requirements
- R1: The count equals the number of positions i where hit_i[i] is 1 and mask bit i is 1. A mask bit of 0 makes that hit line have no effect on count_o.
- R2: A new, independent result appears on count_o every clock cycle, with no stalls between successive samples.
- R3: Hits present before clock edge k appear on count_o just after edge k+6. That is, on the seventh edge, counting edge k as the first, and not on any earlier edge.
- R4: count_o is an unsigned 6-bit binary value from 0 to 48. With all 48 lines asserted and enabled it reads 48.
- R5: When mask_wr_i is 1 at a clock edge, mask_wdata_i is loaded into mask bits 23:0 if mask_sel_i is 0, or into bits 47:24 if mask_sel_i is 1. The other half keeps its value.
- R6: mask_rdata_o shows mask bits 23:0 when mask_sel_i is 0 and bits 47:24 when mask_sel_i is 1. It follows mask_sel_i without a clock.
- R7: A mask written at edge e applies to samples taken from edge e+1 onward. The sample taken at edge e itself uses the old mask.
- R8: Reset (rst_n low, asynchronous) sets every mask bit to 1, count_o to 0 and count_vld_o to 0, and enters FILL. After release, count_vld_o rises just after the seventh edge, when the controller takes the FILL-to-RUN transition. It then stays at 1, and count_o is 0 whenever count_vld_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (40 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 48 | Hit lines to be counted |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_sel_i | input | 1 | Selects the mask half: 0 for bits 23:0, 1 for bits 47:24 |
| mask_wdata_i | input | 24 | Mask write data |
| mask_rdata_o | output | 24 | Selected mask half, read back |
| count_o | output | 6 | Masked count of asserted hits |
| count_vld_o | output | 1 | High once the pipeline carries real samples |

## Verification
The assertions check four things on every cycle:
- count_o always equals the masked population count of the sample taken seven edges earlier.
- count_o never exceeds 48.
- Mask halves change only when addressed by a write.
- The controller never leaves RUN, and count_o stays zero until valid.

Only the bench scenarios can show the following:
- The exact edge on which count_vld_o rises after reset.
- The readback values.
- That a result does not appear one clock early.
- The old-mask/new-mask boundary around a write.
- The sustained stream of distinct results, one per clock.

// File: rtl/maj_pkg.sv
package maj_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } maj_state_e;

endpackage

// File: rtl/maj_mask_reg.sv
module maj_mask_reg #(
    parameter int N_IN  = 48,
    parameter int BUS_W = 24,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic [N_IN-1:0]  mask_o
);

    localparam int NWORD = N_IN / BUS_W;

    logic [N_IN-1:0] mask_q;

    for (genvar g = 0; g < NWORD; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g*BUS_W +: BUS_W] <= '1;
            end else if (wr_i && (sel_i == SEL_W'(g))) begin
                mask_q[g*BUS_W +: BUS_W] <= wdata_i;
            end
        end

        // R5: an addressed write loads this half
        p_mask_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && (sel_i == SEL_W'(g))) |=> (mask_q[g*BUS_W +: BUS_W] == $past(wdata_i)));

        // R5: a half that is not addressed keeps its value
        p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && (sel_i == SEL_W'(g))) |=> $stable(mask_q[g*BUS_W +: BUS_W]));
    end

    always_comb begin
        rdata_o = '0;
        for (int g = 0; g < NWORD; g++) begin
            if (sel_i == SEL_W'(g)) begin
                rdata_o = mask_q[g*BUS_W +: BUS_W];
            end
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/maj_leaf_count.sv
module maj_leaf_count #(
    parameter int N_IN = 48,
    parameter int GRP  = 8,
    parameter int NL2  = 8,
    parameter int CW   = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         hit_i,
    input  logic [N_IN-1:0]         mask_i,
    output logic [NL2-1:0][CW-1:0]  leaf_o
);

    localparam int PADW = NL2 * GRP;

    logic [N_IN-1:0]        gated_q;
    logic [PADW-1:0]        padded;
    logic [NL2-1:0][CW-1:0] leaf_d;
    logic [NL2-1:0][CW-1:0] leaf_q;

    // Stage 1: sample and gate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gated_q <= '0;
        end else begin
            gated_q <= hit_i & mask_i;
        end
    end

    assign padded = PADW'(gated_q);

    always_comb begin
        for (int l = 0; l < NL2; l++) begin
            leaf_d[l] = '0;
            for (int b = 0; b < GRP; b++) begin
                leaf_d[l] = leaf_d[l] + CW'(padded[l*GRP + b]);
            end
        end
    end

    // Stage 2: group counts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            leaf_q <= '0;
        end else begin
            leaf_q <= leaf_d;
        end
    end

    assign leaf_o = leaf_q;

    // R1: a line disabled at sample time never reaches the sampled vector
    p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((gated_q & ~$past(mask_i)) == '0));

endmodule

// File: rtl/maj_adder_tree.sv
module maj_adder_tree #(
    parameter int NL2  = 8,
    parameter int LVLS = 3,
    parameter int CW   = 6,
    parameter int PAD  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NL2-1:0][CW-1:0] leaf_i,
    output logic [CW-1:0]          sum_o
);

    logic [LVLS:1][NL2-1:0][CW-1:0] tree_q;
    logic [CW-1:0]                  root;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tree_q <= '0;
        end else begin
            for (int l = 1; l <= LVLS; l++) begin
                for (int j = 0; j < NL2 / 2; j++) begin
                    if (l == 1) begin
                        tree_q[l][j] <= leaf_i[2*j] + leaf_i[2*j+1];
                    end else begin
                        tree_q[l][j] <= tree_q[l-1][2*j] + tree_q[l-1][2*j+1];
                    end
                end
            end
        end
    end

    assign root = tree_q[LVLS][0];

    if (PAD > 0) begin : g_pad
        logic [CW-1:0] pad_q [PAD];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int p = 0; p < PAD; p++) begin
                    pad_q[p] <= '0;
                end
            end else begin
                pad_q[0] <= root;
                for (int p = 1; p < PAD; p++) begin
                    pad_q[p] <= pad_q[p-1];
                end
            end
        end

        assign sum_o = pad_q[PAD-1];
    end else begin : g_nopad
        assign sum_o = root;
    end

endmodule

// File: rtl/maj_ctrl.sv
module maj_ctrl
    import maj_pkg::*;
#(
    parameter int LATENCY = 7
) (
    input  logic clk,
    input  logic rst_n,
    output logic vld_o
);

    localparam int FW = $clog2(LATENCY + 1);

    maj_state_e    state_q, state_d;
    logic [FW-1:0] fill_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (fill_q == FW'(LATENCY - 1)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FILL: vld_o = 1'b0;
            ST_RUN:  vld_o = 1'b1;
            default: vld_o = 1'b0;
        endcase
    end

    // R8: RUN is held until reset
    p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

    // R8: the fill counter freezes once running
    p_fill_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(fill_q));

endmodule

// File: rtl/majority_counter.sv
module majority_counter #(
    parameter int N_IN    = 48,
    parameter int BUS_W   = 24,
    parameter int GRP     = 8,
    parameter int LATENCY = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_IN-1:0]              hit_i,
    input  logic                         mask_wr_i,
    input  logic                         mask_sel_i,
    input  logic [BUS_W-1:0]             mask_wdata_i,
    output logic [BUS_W-1:0]             mask_rdata_o,
    output logic [$clog2(N_IN+1)-1:0]    count_o,
    output logic                         count_vld_o
);

    localparam int CW    = $clog2(N_IN + 1);
    localparam int NLEAF = (N_IN + GRP - 1) / GRP;
    localparam int LVLS  = (NLEAF > 1) ? $clog2(NLEAF) : 1;
    localparam int NL2   = 1 << LVLS;
    localparam int PAD   = LATENCY - 2 - LVLS;

    logic [N_IN-1:0]        mask_w;
    logic [NL2-1:0][CW-1:0] leaf_w;
    logic [CW-1:0]          sum_w;
    logic                   vld_w;

    maj_mask_reg #(
        .N_IN  (N_IN),
        .BUS_W (BUS_W),
        .SEL_W (1)
    ) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr_i),
        .sel_i   (mask_sel_i),
        .wdata_i (mask_wdata_i),
        .rdata_o (mask_rdata_o),
        .mask_o  (mask_w)
    );

    maj_leaf_count #(
        .N_IN (N_IN),
        .GRP  (GRP),
        .NL2  (NL2),
        .CW   (CW)
    ) i_leaf (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit_i),
        .mask_i (mask_w),
        .leaf_o (leaf_w)
    );

    maj_adder_tree #(
        .NL2  (NL2),
        .LVLS (LVLS),
        .CW   (CW),
        .PAD  (PAD)
    ) i_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .leaf_i (leaf_w),
        .sum_o  (sum_w)
    );

    maj_ctrl #(
        .LATENCY (LATENCY)
    ) i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_o (vld_w)
    );

    assign count_o     = sum_w;
    assign count_vld_o = vld_w;

    // R4: never above the number of inputs
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o <= CW'(N_IN)));

    // R8: no stale data before the pipeline is full
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !count_vld_o |-> (count_o == '0));

    if (LATENCY == 7) begin : g_lat_chk
        // R3: result equals the masked count sampled seven edges earlier
        p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
            count_vld_o |-> (int'(count_o) == $countones($past(hit_i & mask_w, 7))));
    end

endmodule

// File: tb/test_majority_counter.sv
module test_majority_counter;

    localparam int N = 48;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] hit;
    logic         wr;
    logic         sel;
    logic [W-1:0] wdata;
    logic [W-1:0] rdata;
    logic [5:0]   cnt;
    logic         vld;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    majority_counter i_majority_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit),
        .mask_wr_i    (wr),
        .mask_sel_i   (sel),
        .mask_wdata_i (wdata),
        .mask_rdata_o (rdata),
        .count_o      (cnt),
        .count_vld_o  (vld)
    );

    function automatic int pop(input logic [N-1:0] v);
        int s = 0;
        for (int i = 0; i < N; i++) if (v[i]) s++;
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_mask(input logic s, input logic [W-1:0] d);
        @(negedge clk);
        wr = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic set_mask(input logic [N-1:0] m);
        wr_mask(1'b0, m[W-1:0]);
        wr_mask(1'b1, m[N-1:W]);
    endtask

    task automatic count_after7(input logic [N-1:0] h, input logic [N-1:0] m, input string req);
        @(negedge clk);
        hit = h;
        repeat (7) @(posedge clk);
        @(negedge clk);
        check(req, int'(cnt), pop(h & m));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hit = '0; wr = 1'b0; sel = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        check("R8 count in reset", int'(cnt), 0);
        check("R8 valid in reset", int'(vld), 0);
        check("R8 mask lo reset", int'(rdata), 24'hFFFFFF);
        rst_n = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R8 valid after edge %0d", k), int'(vld), (k == 7) ? 1 : 0);
            if (k < 7) check("R8 count zero while filling", int'(cnt), 0);
        end
        repeat (4) begin
            @(negedge clk);
            check("R8 valid stays high", int'(vld), 1);
        end
    endtask

    task automatic t_mask_rw();
        wr_mask(1'b0, 24'h123456);
        wr_mask(1'b1, 24'hABCDEF);
        sel = 1'b0; #1;
        check("R6 read lo", int'(rdata), 24'h123456);
        sel = 1'b1; #1;
        check("R6 read hi", int'(rdata), 24'hABCDEF);
        wr_mask(1'b0, 24'h00000F);
        sel = 1'b1; #1;
        check("R5 hi unchanged by lo write", int'(rdata), 24'hABCDEF);
        sel = 1'b0; #1;
        check("R5 lo written", int'(rdata), 24'h00000F);
    endtask

    task automatic t_basic();
        logic [N-1:0] m = '1;
        set_mask(m);
        count_after7('1, m, "R4 all lines set gives 48");
        count_after7(48'h1, m, "R1 lowest line");
        count_after7(48'h8000_0000_0000, m, "R1 highest line");
        count_after7(48'h5555_5555_5555, m, "R1 alternating");
        count_after7('0, m, "R1 no lines");
    endtask

    task automatic t_masked();
        logic [N-1:0] m;
        m = {24'hFFFFFF, 24'h000000};
        set_mask(m);
        count_after7('1, m, "R1 lower half masked off");
        m = {24'h000001, 24'h800000};
        set_mask(m);
        count_after7('1, m, "R1 two enabled lines");
        m = '0;
        set_mask(m);
        count_after7('1, m, "R1 all masked has no effect");
    endtask

    task automatic t_latency();
        set_mask('1);
        @(negedge clk);
        hit = '0;
        repeat (8) @(negedge clk);
        hit = '1;
        repeat (6) @(negedge clk);
        check("R3 not visible after six edges", int'(cnt), 0);
        @(negedge clk);
        check("R3 visible after seventh edge", int'(cnt), 48);
    endtask

    task automatic t_stream();
        localparam int NP = 24;
        int exp_q [NP];
        set_mask('1);
        for (int c = 0; c < NP + 7; c++) begin
            @(negedge clk);
            if (c >= 7) check($sformatf("R2 stream item %0d", c - 7), int'(cnt), exp_q[c-7]);
            if (c < NP) begin
                logic [63:0] t;
                t = (64'd1 << ((c * 7) % 49)) - 64'd1;
                hit = t[N-1:0];
                exp_q[c] = pop(t[N-1:0]);
            end else begin
                hit = '0;
            end
        end
    endtask

    task automatic t_mask_timing();
        set_mask('1);
        @(negedge clk);
        hit = '0;
        repeat (8) @(negedge clk);
        wr = 1'b1; sel = 1'b0; wdata = '0; hit = '1;
        @(negedge clk);
        wr = 1'b0;
        repeat (5) @(negedge clk);
        @(negedge clk);
        check("R7 sample at write edge uses old mask", int'(cnt), 48);
        @(negedge clk);
        check("R7 next sample uses new mask", int'(cnt), 24);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_mask_rw();
        t_basic();
        t_masked();
        t_latency();
        t_stream();
        t_mask_timing();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule